// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM refreshed without help from software. A free-running interval timer marks when one more row refresh has fallen due and adds it to a small count of owed refreshes. While any refresh is owed, the block asks the access controller for the memory bus with a request/grant handshake. Once it holds the grant, it runs refresh cycles back to back until nothing is owed, or until the grant is withdrawn at the end of a cycle.

Two refresh styles are available. In the first style, CAS falls before RAS, so the DRAM takes the row from its own counter and the address bus stays at zero. In the second style, CAS stays high, the block's own row counter is placed on the address bus, and RAS alone is pulsed. The mode input is static configuration and is sampled only while the block is idle. The number of rows, and therefore the refresh interval, is set separately for each style. Strobe widths come from nanosecond limits and the clock period.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, req_o, drive_o, ovf_o and addr_o are 0, and ras_n_o and cas_n_o are 1.
- R2: One refresh falls due every RETENTION_NS/(rows*CLK_NS) clock cycles. Here rows is ROWS_CBR when the sampled mode is 0 (CAS-before-RAS) and ROWS_RAS when it is 1 (RAS-only).
- R3: The owed-refresh count saturates at PEND_MAX (8). An interval that expires while the count is full, and no refresh completes in that cycle, sets ovf_o, which stays set until reset.
- R4: In mode 0, cas_n_o falls LEAD_CYC cycles before ras_n_o falls and stays low while ras_n_o is low. addr_o stays 0 throughout.
- R5: In mode 1, cas_n_o stays 1. addr_o carries the row counter during the lead cycles and while ras_n_o is low, and is 0 in the other cycles.
- R6: ras_n_o stays low for ceil(TRAS_NS/CLK_NS) cycles per refresh. It is then high for at least ceil(TRP_NS/CLK_NS) cycles. A whole cycle spans at least ceil(TRC_NS/CLK_NS) clocks.
- R7: req_o is 1 whenever refreshes are owed or a refresh cycle is in progress, and 0 otherwise.
- R8: A refresh cycle starts only from idle with grant_i high, or at the end of a cycle with grant_i high and refreshes still owed. Otherwise the block returns to idle at that boundary.
- R9: The row counter rises by one after each mode-1 refresh and wraps from ROWS_RAS-1 to 0. Mode-0 refreshes leave it unchanged.
- R10: A change on mode_i while a cycle is in progress has no effect until the block is idle again.
- R11: While idle, drive_o is 0, both strobes are 1 and addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Refresh style: 0 CAS-before-RAS, 1 RAS-only |
| grant_i | input | 1 | Bus grant from the access controller |
| req_o | output | 1 | Bus request to the access controller |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_o | output | ADDR_W | Row address for RAS-only refresh |
| drive_o | output | 1 | Strobes and address are driven by this block |
| ovf_o | output | 1 | Sticky overflow of the owed-refresh count |

## Verification
The assertions assume that grant_i is only meaningful at cycle boundaries. The block may therefore see grant_i fall in the middle of a cycle and must simply finish that cycle. The stimulus deliberately drops grant_i at arbitrary times and toggles mode_i mid-cycle to show that both are ignored there. The assertions also take it that mode_i is a level held for many cycles. Even so, the bench changes it every few clocks in one phase, and the reference model samples it only at idle.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_LEAD  = 2'd1,
      SQ_STROBE = 2'd2,
      SQ_RECOV = 2'd3
   } seq_state_e;

   typedef enum logic {
      MODE_CBR = 1'b0,
      MODE_ROW = 1'b1
   } ref_mode_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/refsch_interval.sv
module refsch_interval #(
   parameter int INT_A = 1562,
   parameter int INT_B = 781
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_b,
   output logic tick
);
   localparam int INT_MAX = (INT_A > INT_B) ? INT_A : INT_B;
   localparam int CW      = $clog2(INT_MAX + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;

   if (INT_A < 2 || INT_B < 2) begin : g_bad_interval
      $error("refsch_interval: interval must be at least two cycles");
   end

   assign limit = sel_b ? CW'(INT_B - 1) : CW'(INT_A - 1);
   assign tick  = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/refsch_pending.sv
module refsch_pending #(
   parameter int PEND_MAX = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          due,
   input  logic                          done,
   output logic [$clog2(PEND_MAX+1)-1:0] count,
   output logic                          nonzero,
   output logic                          ovf
);
   localparam int PW = $clog2(PEND_MAX + 1);

   if (PEND_MAX < 1) begin : g_bad_max
      $error("refsch_pending: PEND_MAX must be positive");
   end

   logic [PW-1:0] cnt_q;
   logic          ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (due && !done) begin
            if (cnt_q == PW'(PEND_MAX)) begin
               ovf_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (done && !due && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign count   = cnt_q;
   assign nonzero = (cnt_q != '0);
   assign ovf     = ovf_q;
endmodule

// File: rtl/refsch_row_ctr.sv
module refsch_row_ctr #(
   parameter int ROWS = 8192
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv,
   output logic [$clog2(ROWS)-1:0] row
);
   localparam int  RW   = $clog2(ROWS);
   localparam bit  POW2 = ((ROWS & (ROWS - 1)) == 0);

   if (ROWS < 2) begin : g_bad_rows
      $error("refsch_row_ctr: ROWS must be at least two");
   end

   logic [RW-1:0] row_q;

   if (POW2) begin : g_wrap_natural
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   row_q <= '0;
         else if (adv) row_q <= row_q + 1'b1;
      end
   end else begin : g_wrap_compare
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_q <= '0;
         end else if (adv) begin
            if (row_q == RW'(ROWS - 1)) row_q <= '0;
            else                         row_q <= row_q + 1'b1;
         end
      end
   end

   assign row = row_q;
endmodule

// File: rtl/refsch_seq.sv
module refsch_seq
   import refsch_pkg::*;
#(
   parameter int LEAD_CYC = 1,
   parameter int RAS_CYC  = 5,
   parameter int PRE_CYC  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_i,
   input  logic grant_i,
   input  logic owed,
   output logic done,
   output logic mode_q,
   output logic busy,
   output logic ras_n,
   output logic cas_n,
   output logic addr_en
);
   localparam int PH_MAX = max2(max2(LEAD_CYC, RAS_CYC), PRE_CYC);
   localparam int PHW    = $clog2(PH_MAX + 1);

   if (LEAD_CYC < 1 || RAS_CYC < 1 || PRE_CYC < 1) begin : g_bad_phase
      $error("refsch_seq: every phase needs at least one cycle");
   end

   seq_state_e     st_q;
   logic [PHW-1:0] ph_q;
   logic           mode_r;
   logic           lead_end, ras_end, pre_end, in_pulse, cbr;

   assign lead_end = (ph_q == PHW'(LEAD_CYC - 1));
   assign ras_end  = (ph_q == PHW'(RAS_CYC - 1));
   assign pre_end  = (ph_q == PHW'(PRE_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         ph_q   <= '0;
         mode_r <= MODE_CBR;
      end else begin
         unique case (st_q)
            SQ_IDLE: begin
               mode_r <= mode_i;
               ph_q   <= '0;
               if (owed && grant_i) st_q <= SQ_LEAD;
            end
            SQ_LEAD: begin
               if (lead_end) begin
                  st_q <= SQ_STROBE;
                  ph_q <= '0;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            SQ_STROBE: begin
               if (ras_end) begin
                  st_q <= SQ_RECOV;
                  ph_q <= '0;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            SQ_RECOV: begin
               if (pre_end) begin
                  ph_q <= '0;
                  st_q <= (owed && grant_i) ? SQ_LEAD : SQ_IDLE;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign cbr      = (mode_r == MODE_CBR);
   assign in_pulse = (st_q == SQ_LEAD) || (st_q == SQ_STROBE);
   assign done     = (st_q == SQ_STROBE) && ras_end;
   assign busy     = (st_q != SQ_IDLE);
   assign mode_q   = mode_r;
   assign ras_n    = !(st_q == SQ_STROBE);
   assign cas_n    = !(in_pulse && cbr);
   assign addr_en  = in_pulse && !cbr;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import refsch_pkg::*;
#(
   parameter int CLK_NS       = 10,
   parameter int RETENTION_NS = 64_000_000,
   parameter int ROWS_CBR     = 4096,
   parameter int ROWS_RAS     = 8192,
   parameter int TRAS_NS      = 50,
   parameter int TRP_NS       = 30,
   parameter int TRC_NS       = 90,
   parameter int LEAD_CYC     = 1,
   parameter int PEND_MAX     = 8,
   localparam int ADDR_W      = $clog2(ROWS_RAS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_i,
   input  logic              grant_i,
   output logic              req_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              drive_o,
   output logic              ovf_o
);
   localparam int INT_CBR = RETENTION_NS / (ROWS_CBR * CLK_NS);
   localparam int INT_ROW = RETENTION_NS / (ROWS_RAS * CLK_NS);
   localparam int RAS_CYC = ceil_div(TRAS_NS, CLK_NS);
   localparam int TRP_CYC = ceil_div(TRP_NS, CLK_NS);
   localparam int TRC_CYC = ceil_div(TRC_NS, CLK_NS);
   localparam int PRE_CYC = max2(TRP_CYC, TRC_CYC - LEAD_CYC - RAS_CYC);
   localparam int PW      = $clog2(PEND_MAX + 1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("dram_refresh_sched: CLK_NS must be positive");
   end
   if (INT_CBR <= LEAD_CYC + RAS_CYC + PRE_CYC) begin : g_bad_budget
      $error("dram_refresh_sched: refresh interval shorter than one cycle");
   end

   logic              due, done, owed, busy, mode_q, addr_en;
   logic [PW-1:0]     pend_cnt;
   logic [ADDR_W-1:0] row;

   refsch_interval #(.INT_A(INT_CBR), .INT_B(INT_ROW)) u_interval (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_b (mode_q),
      .tick  (due)
   );

   refsch_pending #(.PEND_MAX(PEND_MAX)) u_pending (
      .clk     (clk),
      .rst_n   (rst_n),
      .due     (due),
      .done    (done),
      .count   (pend_cnt),
      .nonzero (owed),
      .ovf     (ovf_o)
   );

   refsch_row_ctr #(.ROWS(ROWS_RAS)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (done && mode_q),
      .row   (row)
   );

   refsch_seq #(.LEAD_CYC(LEAD_CYC), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (mode_i),
      .grant_i (grant_i),
      .owed    (owed),
      .done    (done),
      .mode_q  (mode_q),
      .busy    (busy),
      .ras_n   (ras_n_o),
      .cas_n   (cas_n_o),
      .addr_en (addr_en)
   );

   assign req_o   = owed || busy;
   assign drive_o = busy;
   assign addr_o  = addr_en ? row : '0;
endmodule

// File: rtl/refsch_checker.sv
module refsch_checker #(
   parameter int ADDR_W   = 13,
   parameter int PEND_MAX = 8,
   parameter int PW       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              grant_i,
   input logic              req_o,
   input logic              ras_n_o,
   input logic              cas_n_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              drive_o,
   input logic              ovf_o,
   input logic [PW-1:0]     pend_cnt
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_o |-> (ras_n_o && cas_n_o && addr_o == '0)); // R11
   AST_CBR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n_o |-> (addr_o == '0)); // R4
   AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o)); // R4
   AST_RAS_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n_o) |=> ras_n_o); // R6
   AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= PW'(PEND_MAX)); // R3
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o); // R3
   AST_REQ_COVERS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      drive_o |-> req_o); // R7
   AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_o) |-> $past(grant_i)); // R8
   AST_ADDR_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n_o && $past(!ras_n_o)) |-> $stable(addr_o)); // R5
endmodule

bind dram_refresh_sched refsch_checker #(
   .ADDR_W   (ADDR_W),
   .PEND_MAX (PEND_MAX),
   .PW       (PW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .grant_i  (grant_i),
   .req_o    (req_o),
   .ras_n_o  (ras_n_o),
   .cas_n_o  (cas_n_o),
   .addr_o   (addr_o),
   .drive_o  (drive_o),
   .ovf_o    (ovf_o),
   .pend_cnt (pend_cnt)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
   localparam int CLK_PERIOD = 10;
   localparam int RET_NS     = 40960;
   localparam int R_CBR      = 16;
   localparam int R_RAS      = 32;
   localparam int AW         = 5;
   localparam int INT0       = RET_NS / (R_CBR * CLK_PERIOD);
   localparam int INT1       = RET_NS / (R_RAS * CLK_PERIOD);
   localparam int T_LEAD     = 1;
   localparam int T_RAS      = 5;
   localparam int T_PRE      = 3;

   logic clk = 1'b0, rst_n = 1'b0, mode_i = 1'b0, grant_i = 1'b0;
   logic req_o, ras_n_o, cas_n_o, drive_o, ovf_o;
   logic [AW-1:0] addr_o;

   int n_checks = 0, n_fail = 0;
   int m_cnt, m_pend, m_st, m_ph, m_mode, m_row, m_err;
   int low_run = 0;
   bit done_sim = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_refresh_sched #(
      .CLK_NS(CLK_PERIOD), .RETENTION_NS(RET_NS), .ROWS_CBR(R_CBR), .ROWS_RAS(R_RAS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .grant_i(grant_i), .req_o(req_o),
      .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .addr_o(addr_o), .drive_o(drive_o), .ovf_o(ovf_o)
   );

   task automatic chk(input int act, input int exp, input string tag);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   // reference model: state 0 idle, 1 lead, 2 ras low, 3 recovery
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pend = 0; m_st = 0; m_ph = 0; m_mode = 0; m_row = 0; m_err = 0;
      end else begin
         int lim, p;
         bit tick, fin;
         int st_n, ph_n, mode_n, row_n;
         lim  = (m_mode == 1) ? INT1 : INT0;
         tick = (m_cnt >= lim - 1);
         fin  = (m_st == 2) && (m_ph == T_RAS - 1);
         p    = m_pend + (tick ? 1 : 0) - (fin ? 1 : 0);
         if (p > 8) begin p = 8; m_err = 1; end
         st_n = m_st; ph_n = m_ph + 1; mode_n = m_mode; row_n = m_row;
         case (m_st)
            0: begin
               mode_n = mode_i; ph_n = 0;
               if (m_pend != 0 && grant_i) st_n = 1;
            end
            1: if (m_ph == T_LEAD - 1) begin st_n = 2; ph_n = 0; end
            2: if (fin) begin
                  st_n = 3; ph_n = 0;
                  if (m_mode == 1) row_n = (m_row + 1) % R_RAS;
               end
            default: if (m_ph == T_PRE - 1) begin
                  ph_n = 0;
                  st_n = (m_pend != 0 && grant_i) ? 1 : 0;
               end
         endcase
         m_cnt = tick ? 0 : m_cnt + 1;
         m_pend = p; m_st = st_n; m_ph = ph_n; m_mode = mode_n; m_row = row_n;
      end
      #2;
      if (rst_n && !done_sim) begin
         bit pulse;
         pulse = (m_st == 1) || (m_st == 2);
         chk(req_o, (m_pend != 0 || m_st != 0) ? 1 : 0, "R7 req_o");
         chk(drive_o, (m_st != 0) ? 1 : 0, "R11 drive_o");
         chk(ras_n_o, (m_st == 2) ? 0 : 1, "R6 R8 ras_n_o");
         chk(cas_n_o, (pulse && m_mode == 0) ? 0 : 1, "R4 R10 cas_n_o");
         chk(addr_o, (pulse && m_mode == 1) ? m_row : 0, "R5 R9 addr_o");
         chk(ovf_o, m_err, "R2 R3 ovf_o");
         // independent width check on the strobe
         if (!ras_n_o) low_run++;
         else begin
            if (low_run != 0) chk(low_run, T_RAS, "R6 ras low width");
            low_run = 0;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_o, 0, "R1 req_o"); chk(ras_n_o, 1, "R1 ras_n_o");
      chk(cas_n_o, 1, "R1 cas_n_o"); chk(drive_o, 0, "R1 drive_o");
      chk(addr_o, 0, "R1 addr_o"); chk(ovf_o, 0, "R1 ovf_o");
      rst_n = 1'b1;
      // R2 R4: CAS-before-RAS mode with grant always given
      grant_i = 1'b1;
      repeat (INT0 - 2) @(negedge clk);
      chk(req_o, 0, "R2 no request before first interval");
      repeat (4 * INT0) @(negedge clk);
      // R3: withhold the bus until the owed count overflows
      grant_i = 1'b0;
      repeat (10 * INT0) @(negedge clk);
      chk(ovf_o, 1, "R3 overflow flagged");
      chk(drive_o, 0, "R8 no drive without grant");
      grant_i = 1'b1;  // R8 burst catch-up
      repeat (INT0) @(negedge clk);
      // R5 R9: RAS-only mode; run past a full row wrap
      mode_i = 1'b1;
      repeat ((R_RAS + 6) * INT1) @(negedge clk);
      // R10: mode toggled every few cycles
      for (int i = 0; i < 1200; i++) begin
         if (i % 3 == 0) mode_i = ~mode_i;
         @(negedge clk);
      end
      // R8: grant dropped at arbitrary points
      for (int i = 0; i < 3000; i++) begin
         grant_i = ((i % 47) < 29);
         mode_i  = (i >= 1500);
         @(negedge clk);
      end
      chk(ovf_o, 1, "R3 overflow stays set");
      done_sim = 1;
      @(negedge clk);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule